// File: doc/BRIEF.md
# Power-Management Wake and Interrupt Source Conditioner

This block takes the raw, asynchronous power-management inputs of a system controller and turns them into clean event requests. There are seven sources: power button, sleep button, display lid, external SMI request, SMBus alert, ring indicator and battery-low. Each pin is brought into the core clock domain by a two-flop synchroniser.

The power button and the lid can also pass through an optional debounce filter. The filter counts ticks of a slow strobe, one pulse per period of a 32.768 kHz clock, so that a change must hold for about 200 µs before it is accepted.

Every source has its own enable bit. It also has its own rising-edge and falling-edge detect masks and three routing masks, which steer a detected event to the SMI, IRQ or wake output as a one-cycle pulse. Each event also sets a sticky status bit. Software clears a status bit by writing one to it through a plain write/read register port.

Top module: `pm_event_cond`

## Requirements
- R1: While `rst_n` is low, every register reads 0 and `smi_o`, `irq_o` and `wake_o` are low. Idle pin levels after reset are high for all sources except the lid, which idles low.
- R2: When CTRL bit 0 is 1, a change on the power button (source 0) or the lid (source 2) is accepted only after the synchronised level has differed from the accepted level for DB_TICKS consecutive `slow_tick` pulses (default 7, about 200 µs). A shorter excursion produces no event.
- R3: When CTRL bit 0 is 0, a pin change that is a detected edge produces its output pulse at the third rising `clk` edge after the change. The pulse is high for exactly one cycle.
- R4: Source i detects a rising edge when RISE bit i is 1 and a falling edge when FALL bit i is 1. With both bits set on the lid, both directions of the lid raise events.
- R5: An enabled external SMI source (source 3, FALL bit set) raises an SMI on a falling edge. With EN bit 3 clear, the falling edge sets no status and produces no pulse.
- R6: An event on source i pulses `smi_o` if RSMI bit i is 1, `irq_o` if RIRQ bit i is 1 and `wake_o` if RWAKE bit i is 1, in any combination. This lets the SMBus alert be routed to IRQ, SMI or wake.
- R7: With EN bit 1 clear, sleep button edges set no status bit and raise no pulse.
- R8: A status bit is set by an enabled event and stays set until software writes 1 to it at STAT. Writing 0 leaves it set. When an event and a clear hit the same bit in the same cycle, the bit ends set.
- R9: A falling edge on the ring indicator (source 5), when enabled and routed to wake, pulses `wake_o`.
- R10: Register addresses are STAT=0 (read, write-one-to-clear), EN=1, RISE=2, FALL=3, RSMI=4, RIRQ=5, RWAKE=6 and CTRL=7. Bit i of the first seven registers refers to source i, in this order: 0 power button, 1 sleep button, 2 lid, 3 external SMI, 4 SMBus alert, 5 ring, 6 battery-low. Reads are combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Resume reset, active low, asynchronous |
| slow_tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| pwr_btn_n | input | 1 | Power button, active low |
| slp_btn_n | input | 1 | Sleep button, active low |
| lid_in | input | 1 | Display lid level |
| ext_smi_n | input | 1 | External SMI request, active low |
| smb_alert_n | input | 1 | SMBus alert, active low |
| ring_n | input | 1 | Ring indicator, active low |
| batt_low_n | input | 1 | Battery low, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Register read data |
| smi_o | output | 1 | SMI request pulse |
| irq_o | output | 1 | IRQ request pulse |
| wake_o | output | 1 | Wake event pulse |

## Verification
The table drives each source in turn through both pin directions with a fixed enable, polarity and routing setup. This separates the sources whose edges are masked from those that fire, and shows whether each one reaches exactly the outputs it is routed to and sets only its own status bit. Directed runs then cover three more cases. The first is a short power-button glitch against a held press with the filter on, which tests whether the tick count gates acceptance. The second is the disabled external SMI source. The third is a clear that lands in the same cycle as a new event, which shows whether set wins over clear.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int SRC_N = 7;
    localparam int ADDR_W = 3;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT  = 3'd0,
        ADR_EN    = 3'd1,
        ADR_RISE  = 3'd2,
        ADR_FALL  = 3'd3,
        ADR_RSMI  = 3'd4,
        ADR_RIRQ  = 3'd5,
        ADR_RWAKE = 3'd6,
        ADR_CTRL  = 3'd7
    } pm_addr_e;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W = 7,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/pm_debounce.sv
module pm_debounce #(
    parameter int   DB_TICKS = 7,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int CNT_W = $clog2(DB_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_TICKS - 1);

    typedef struct packed {
        logic             filt;
        logic [CNT_W-1:0] cnt;
    } db_st_t;

    db_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.filt = din_i;
            st_d.cnt  = '0;
        end else if (din_i == st_q.filt) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.filt = din_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.filt <= RST_VAL;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = en_i ? st_q.filt : din_i;

    // R2: with filtering on, the accepted level moves only on a slow tick
    assert_filt_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && (st_q.filt != $past(st_q.filt))) |-> $past(tick_i));

    // R2: the stability counter never passes its terminal value
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);
endmodule

// File: rtl/pm_event_cond.sv
module pm_event_cond
    import pm_evt_pkg::*;
#(
    parameter int       DB_TICKS = 7,
    parameter src_vec_t DB_MASK  = 7'b0000101,
    parameter src_vec_t IDLE_LVL = 7'b1111011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              pwr_btn_n,
    input  logic              slp_btn_n,
    input  logic              lid_in,
    input  logic              ext_smi_n,
    input  logic              smb_alert_n,
    input  logic              ring_n,
    input  logic              batt_low_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_N-1:0]  reg_wdata,
    output logic [SRC_N-1:0]  reg_rdata,
    output logic              smi_o,
    output logic              irq_o,
    output logic              wake_o
);
    typedef struct packed {
        src_vec_t prev;
        src_vec_t stat;
        src_vec_t en;
        src_vec_t rise;
        src_vec_t fall;
        src_vec_t rsmi;
        src_vec_t rirq;
        src_vec_t rwake;
        logic     dben;
        logic     smi;
        logic     irq;
        logic     wake;
    } core_st_t;

    core_st_t st_d, st_q;
    src_vec_t raw, synced, cond, evt, clr;

    assign raw = {batt_low_n, ring_n, smb_alert_n, ext_smi_n, lid_in, slp_btn_n, pwr_btn_n};

    pm_sync #(.W(SRC_N), .RST_VAL(IDLE_LVL)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        if (DB_MASK[g]) begin : g_db
            pm_debounce #(.DB_TICKS(DB_TICKS), .RST_VAL(IDLE_LVL[g])) db_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick_i (slow_tick),
                .en_i   (st_q.dben),
                .din_i  (synced[g]),
                .dout_o (cond[g])
            );
        end else begin : g_pass
            assign cond[g] = synced[g];
        end
    end

    always_comb begin
        st_d = st_q;
        evt  = ((cond & ~st_q.prev & st_q.rise) |
                (~cond & st_q.prev & st_q.fall)) & st_q.en;
        clr  = (reg_wr && reg_addr == ADR_STAT) ? reg_wdata : '0;

        st_d.prev = cond;
        st_d.stat = (st_q.stat & ~clr) | evt;
        st_d.smi  = |(evt & st_q.rsmi);
        st_d.irq  = |(evt & st_q.rirq);
        st_d.wake = |(evt & st_q.rwake);

        if (reg_wr) begin
            case (pm_addr_e'(reg_addr))
                ADR_EN:    st_d.en    = reg_wdata;
                ADR_RISE:  st_d.rise  = reg_wdata;
                ADR_FALL:  st_d.fall  = reg_wdata;
                ADR_RSMI:  st_d.rsmi  = reg_wdata;
                ADR_RIRQ:  st_d.rirq  = reg_wdata;
                ADR_RWAKE: st_d.rwake = reg_wdata;
                ADR_CTRL:  st_d.dben  = reg_wdata[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= IDLE_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (pm_addr_e'(reg_addr))
            ADR_STAT:  reg_rdata = st_q.stat;
            ADR_EN:    reg_rdata = st_q.en;
            ADR_RISE:  reg_rdata = st_q.rise;
            ADR_FALL:  reg_rdata = st_q.fall;
            ADR_RSMI:  reg_rdata = st_q.rsmi;
            ADR_RIRQ:  reg_rdata = st_q.rirq;
            ADR_RWAKE: reg_rdata = st_q.rwake;
            default:   reg_rdata = {{(SRC_N-1){1'b0}}, st_q.dben};
        endcase
    end

    assign smi_o  = st_q.smi;
    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;

    // R5 R7: a status bit can only newly rise for a source that was enabled
    assert_stat_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat & ~$past(st_q.stat) & ~$past(st_q.en)) == '0);

    // R6: an SMI pulse coincides with a freshly set status bit routed to SMI
    assert_smi_routed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> |(st_q.stat & $past(st_q.rsmi)));

    // R6: same for the IRQ output
    assert_irq_routed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(st_q.stat & $past(st_q.rirq)));

    // R9: same for the wake output
    assert_wake_routed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> |(st_q.stat & $past(st_q.rwake)));
endmodule

// File: tb/pm_event_cond_tb_top.sv
module pm_event_cond_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    // {src[7:5], level[4], exp_smi[3], exp_irq[2], exp_wake[1], exp_stat[0]}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b000_0_1011,  // power button press: smi+wake (R6)
        8'b000_1_0000,  // power button release: masked rise (R4)
        8'b010_1_1001,  // lid open: rise (R4)
        8'b010_0_1001,  // lid close: fall, both edges (R4)
        8'b011_0_1001,  // external SMI falling (R5)
        8'b011_1_0000,  // external SMI rising ignored (R5)
        8'b100_0_0111,  // SMBus alert to irq+wake (R6)
        8'b100_1_0000,
        8'b101_0_0011,  // ring wakes (R9)
        8'b101_1_0000,
        8'b110_0_0101,  // battery low to irq (R6)
        8'b110_1_0000,
        8'b001_0_0000,  // sleep disabled (R7)
        8'b001_1_0000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] pins = 7'b1111011;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [6:0] reg_wdata = '0;
    logic [6:0] reg_rdata;
    logic       smi_o, irq_o, wake_o;
    int         n_chk = 0;
    int         n_fail = 0;
    int         tick_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt + 1) % 4;
        tick     <= (tick_cnt == 3);
    end

    pm_event_cond dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (tick),
        .pwr_btn_n   (pins[0]),
        .slp_btn_n   (pins[1]),
        .lid_in      (pins[2]),
        .ext_smi_n   (pins[3]),
        .smb_alert_n (pins[4]),
        .ring_n      (pins[5]),
        .batt_low_n  (pins[6]),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .smi_o       (smi_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [6:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [6:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] rv;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {smi_o, irq_o, wake_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            chk("R1 register after reset", rv, 0);
        end

        // R10 configuration
        wr(3'd1, 7'b1111101);
        wr(3'd2, 7'b0000100);
        wr(3'd3, 7'b1111111);
        wr(3'd4, 7'b0001101);
        wr(3'd5, 7'b1010000);
        wr(3'd6, 7'b0110001);
        rd(3'd6, rv);
        chk("R10 RWAKE readback", rv, 7'b0110001);

        // table walk: R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            int src;
            src = int'(VEC[v][7:5]);
            @(negedge clk);
            pins[src] = VEC[v][4];
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk("R6 smi pulse", smi_o, VEC[v][3]);
            chk("R6 irq pulse", irq_o, VEC[v][2]);
            chk("R9 wake pulse", wake_o, VEC[v][1]);
            rd(3'd0, rv);
            chk("R8 status set", rv, VEC[v][0] ? (1 << src) : 0);
            @(negedge clk);
            chk("R3 one-cycle pulse", {smi_o, irq_o, wake_o}, 0);
            wr(3'd0, 7'h7F);
        end

        // R8: sticky, write-0 keeps, write-1 clears
        @(negedge clk);
        pins[3] = 1'b0;
        repeat (10) @(negedge clk);
        wr(3'd0, 7'b1110111);
        rd(3'd0, rv);
        chk("R8 write 0 keeps bit", rv, 7'b0001000);
        wr(3'd0, 7'b0001000);
        rd(3'd0, rv);
        chk("R8 write 1 clears bit", rv, 0);
        pins[3] = 1'b1;
        repeat (4) @(negedge clk);

        // R8: set wins over a same-cycle clear
        pins[3] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 7'b0001000;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R3 smi at third edge", smi_o, 1);
        rd(3'd0, rv);
        chk("R8 set beats clear", rv, 7'b0001000);
        pins[3] = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd0, 7'h7F);

        // R5: disabled external SMI source
        wr(3'd1, 7'b1110101);
        @(negedge clk);
        pins[3] = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (smi_o) seen = 1;
            end
            chk("R5 disabled source no smi", seen, 0);
        end
        rd(3'd0, rv);
        chk("R5 disabled source no status", rv, 0);
        pins[3] = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd1, 7'b1111101);

        // R2: debounce of power button
        wr(3'd7, 7'b0000001);
        @(negedge clk);
        pins[0] = 1'b0;
        repeat (12) @(negedge clk);
        pins[0] = 1'b1;
        begin
            int seen = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (smi_o || wake_o) seen = 1;
            end
            chk("R2 glitch rejected", seen, 0);
        end
        rd(3'd0, rv);
        chk("R2 glitch no status", rv, 0);
        pins[0] = 1'b0;
        begin
            int dly = 0;
            while (!smi_o && dly < 100) begin
                @(negedge clk);
                dly++;
            end
            chk("R2 held press accepted", smi_o, 1);
            chk("R2 delay at least 24", int'(dly >= 24), 1);
            chk("R2 delay at most 40", int'(dly <= 40), 1);
        end
        pins[0] = 1'b1;
        repeat (60) @(negedge clk);
        wr(3'd0, 7'h7F);
        wr(3'd7, 7'b0000000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule